// File: doc/BRIEF.md
# Constant Coefficient Multiplier with Signed-Digit Recoding

This block multiplies a signed 27-bit two's-complement sample by a signed 18-bit constant fixed at elaboration. The constant is never fed to a general multiplier. Instead, elaboration rewrites it into a signed-digit form with digits -1, 0 and +1, in which no two neighbouring digits are both non-zero. Each non-zero digit becomes one operand: the input shifted left by that digit's position. The operand is added when the digit is +1 and subtracted when it is -1. With at most nine operands, two levels of 3-input adders reduce them to the product: three adders in the first level and one in the second.

A parameter selects an optional register after each adder level. With it, the latency is two cycles. Without it, the path is purely combinational. A valid flag travels beside the data with the same delay. The output is either the whole 45-bit product or a slice of it chosen by parameters. The slice drops the low bits without rounding.

Top module: `csd_kcm`

## Requirements
- R1: With PIPELINE=1, `dout` equals the exact signed product `din * COEF` (45 bits) two rising clock edges after `din` is sampled.
- R2: With PIPELINE=1, `valid_o` equals the value that `valid_i` had two rising edges earlier.
- R3: With PIPELINE=0, `dout` equals the exact product of the present `din` and `valid_o` equals the present `valid_i`, with no clock edge in between.
- R4: With PIPELINE=1, one rising edge with `rst`=1 makes `valid_o`=0 and `dout`=0.
- R5: The extreme coefficients 131071 (2^17-1) and -131072 (-2^17) give exact products, including for inputs -2^26 and 2^26-1.
- R6: With COEF=0, `dout` is 0 for every input.
- R7: With OUT_MSB=32 and OUT_LSB=16, `dout` equals bits 32 down to 16 of the exact 45-bit product, with lower bits discarded and no rounding.
- R8: Negative inputs in two's complement, including -1 and -2^26, give exact signed products.
- R9: The data path runs every cycle whatever the state of `valid_i`: `valid_i`=0 does not hold or zero `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline registers |
| valid_i | input | 1 | Marks `din` as carrying a sample |
| din | input | IN_W (27) | Signed two's-complement multiplicand |
| valid_o | output | 1 | `valid_i` delayed by the pipeline latency |
| dout | output | OUT_MSB-OUT_LSB+1 (45) | Product, or the selected slice of it |

## Verification
The embedded properties check on every cycle that the product matches a behavioural multiply delayed by the latency, that the valid flag is aligned with the data, that reset clears the outputs, and that a zero coefficient gives zero. Only the bench scenarios show other behaviour. These include the slice selection, the extreme coefficient values and the combinational variant next to the registered one. They also include inputs at the edges of the range, such as -2^26, -1 and alternating bit patterns, along with random samples.

// File: rtl/csd_kcm_pkg.sv
package csd_kcm_pkg;

  localparam int MAX_TERMS = 9;

  // Signed digit at position pos of the non-adjacent recoding of coef.
  function automatic int sd_digit(input int coef, input int pos);
    int x;
    int d;
    x = coef;
    d = 0;
    for (int i = 0; i <= pos; i++) begin
      if ((x & 1) != 0) d = 2 - (x & 3);
      else              d = 0;
      x = x - d;
      x = x >>> 1;
    end
    return d;
  endfunction

  // Position of the k-th non-zero digit, or -1 when fewer exist.
  function automatic int sd_term_pos(input int coef, input int width, input int k);
    int n;
    n = 0;
    for (int p = 0; p < width; p++) begin
      if (sd_digit(coef, p) != 0) begin
        if (n == k) return p;
        n++;
      end
    end
    return -1;
  endfunction

  // 1 when the k-th non-zero digit is -1 (operand subtracted).
  function automatic bit sd_term_neg(input int coef, input int width, input int k);
    int p;
    p = sd_term_pos(coef, width, k);
    if (p < 0) return 1'b0;
    return sd_digit(coef, p) < 0;
  endfunction

endpackage

// File: rtl/kcm_terms.sv
module kcm_terms
  import csd_kcm_pkg::*;
#(
  parameter int IN_W   = 27,
  parameter int COEF_W = 18,
  parameter int COEF   = 46341,
  parameter int PROD_W = IN_W + COEF_W
) (
  input  logic [IN_W-1:0]                    din,
  output logic [MAX_TERMS-1:0][PROD_W-1:0]   term
);

  logic [PROD_W-1:0] din_x;

  assign din_x = {{(PROD_W-IN_W){din[IN_W-1]}}, din};

  for (genvar k = 0; k < MAX_TERMS; k++) begin : g_term
    localparam int POS = sd_term_pos(COEF, COEF_W, k);
    if (POS < 0) begin : g_unused
      assign term[k] = '0;
    end else begin : g_shift
      assign term[k] = din_x << POS;
    end
  end

endmodule

// File: rtl/kcm_add3.sv
module kcm_add3 #(
  parameter int W     = 45,
  parameter bit PIPE  = 1'b1,
  parameter bit INV_A = 1'b0,
  parameter bit INV_B = 1'b0,
  parameter bit INV_C = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s
);

  // Each inverted operand needs a +1 to complete its negation.
  localparam int CIN = int'(INV_A) + int'(INV_B) + int'(INV_C);

  logic [W-1:0] oa, ob, oc, sum;

  assign oa  = INV_A ? ~a : a;
  assign ob  = INV_B ? ~b : b;
  assign oc  = INV_C ? ~c : c;
  assign sum = oa + ob + oc + W'(CIN);

  if (PIPE) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) s <= '0;
      else     s <= sum;
    end
  end else begin : g_comb
    assign s = sum;
  end

endmodule

// File: rtl/csd_kcm.sv
module csd_kcm
  import csd_kcm_pkg::*;
#(
  parameter int IN_W     = 27,
  parameter int COEF_W   = 18,
  parameter int COEF     = 46341,
  parameter bit PIPELINE = 1'b1,
  parameter int OUT_MSB  = IN_W + COEF_W - 1,
  parameter int OUT_LSB  = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid_i,
  input  logic [IN_W-1:0]            din,
  output logic                       valid_o,
  output logic [OUT_MSB-OUT_LSB:0]   dout
);

  localparam int PROD_W = IN_W + COEF_W;
  localparam int GROUPS = MAX_TERMS / 3;

  logic [MAX_TERMS-1:0][PROD_W-1:0] term;
  logic [GROUPS-1:0][PROD_W-1:0]    part;
  logic [PROD_W-1:0]                prod;

  kcm_terms #(
    .IN_W(IN_W), .COEF_W(COEF_W), .COEF(COEF), .PROD_W(PROD_W)
  ) i_terms (
    .din(din), .term(term)
  );

  // First level: every operand slot passes through one adder, so the
  // second level never sees an unregistered operand.
  for (genvar g = 0; g < GROUPS; g++) begin : g_lvl1
    kcm_add3 #(
      .W(PROD_W), .PIPE(PIPELINE),
      .INV_A(sd_term_neg(COEF, COEF_W, 3*g)),
      .INV_B(sd_term_neg(COEF, COEF_W, 3*g+1)),
      .INV_C(sd_term_neg(COEF, COEF_W, 3*g+2))
    ) i_add (
      .clk(clk), .rst(rst),
      .a(term[3*g]), .b(term[3*g+1]), .c(term[3*g+2]),
      .s(part[g])
    );
  end

  kcm_add3 #(
    .W(PROD_W), .PIPE(PIPELINE), .INV_A(1'b0), .INV_B(1'b0), .INV_C(1'b0)
  ) i_add_final (
    .clk(clk), .rst(rst),
    .a(part[0]), .b(part[1]), .c(part[2]),
    .s(prod)
  );

  assign dout = prod[OUT_MSB:OUT_LSB];

  // Behavioural reference for the embedded properties only.
  logic signed [PROD_W-1:0] ref_prod;
  assign ref_prod = PROD_W'($signed(din)) * PROD_W'(signed'(COEF_W'(COEF)));

  if (PIPELINE) begin : g_vld_pipe
    logic [1:0] vld_q;
    logic [1:0] warm;

    always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else     vld_q <= {vld_q[0], valid_i};
    end
    assign valid_o = vld_q[1];

    always_ff @(posedge clk) begin
      if (rst)              warm <= '0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2) |-> (valid_o == $past(valid_i, 2)));                 // R2
    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2) |-> ($signed(prod) == $past(ref_prod, 2)));         // R1
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!valid_o && prod == '0));                          // R4
  end else begin : g_vld_comb
    assign valid_o = valid_i;

    AST_COMB_PRODUCT: assert property (@(posedge clk) disable iff (rst)
      ($signed(prod) == ref_prod) && (valid_o == valid_i));              // R3
  end

  if (COEF == 0) begin : g_zero_chk
    AST_ZERO_COEF: assert property (@(posedge clk) disable iff (rst)
      prod == '0);                                                        // R6
  end

endmodule

// File: tb/test_csd_kcm.sv
module test_csd_kcm;

  localparam int IN_W  = 27;
  localparam int PW    = 45;
  localparam int C_MID = 46341;
  localparam int C_MAX = 131071;
  localparam int C_MIN = -131072;
  localparam int C_CMB = -21846;
  localparam int NVEC  = 12;

  localparam logic [IN_W-1:0] VEC [NVEC] = '{
    27'h4000000, 27'h3FFFFFF, 27'h0000000, 27'h0000001,
    27'h7FFFFFF, 27'h2AAAAAA, 27'h5555555, 27'h0003039,
    27'h7FFCFC7, 27'h4000001, 27'h1234567, 27'h6EDCBA9
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [IN_W-1:0] din = '0;

  logic v_mid, v_max, v_min, v_zero, v_trn, v_cmb;
  logic [PW-1:0] d_mid, d_max, d_min, d_zero, d_cmb;
  logic [16:0]   d_trn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  csd_kcm #(.COEF(C_MID)) i_csd_kcm (
    .clk(clk), .rst(rst), .valid_i(valid_i), .din(din), .valid_o(v_mid), .dout(d_mid));
  csd_kcm #(.COEF(C_MAX)) i_kcm_max (
    .clk(clk), .rst(rst), .valid_i(valid_i), .din(din), .valid_o(v_max), .dout(d_max));
  csd_kcm #(.COEF(C_MIN)) i_kcm_min (
    .clk(clk), .rst(rst), .valid_i(valid_i), .din(din), .valid_o(v_min), .dout(d_min));
  csd_kcm #(.COEF(0)) i_kcm_zero (
    .clk(clk), .rst(rst), .valid_i(valid_i), .din(din), .valid_o(v_zero), .dout(d_zero));
  csd_kcm #(.COEF(C_MID), .OUT_MSB(32), .OUT_LSB(16)) i_kcm_trn (
    .clk(clk), .rst(rst), .valid_i(valid_i), .din(din), .valid_o(v_trn), .dout(d_trn));
  csd_kcm #(.COEF(C_CMB), .PIPELINE(1'b0)) i_kcm_cmb (
    .clk(clk), .rst(rst), .valid_i(valid_i), .din(din), .valid_o(v_cmb), .dout(d_cmb));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint mul(input logic [IN_W-1:0] x, input int c);
    return longint'($signed(x)) * longint'(c);
  endfunction

  // Drive one sample, check the combinational instance at once and the
  // registered instances after two rising edges.
  task automatic apply(input logic [IN_W-1:0] x);
    longint pm;
    @(negedge clk);
    din = x;
    #1;
    chk("R3 comb product", longint'($signed(d_cmb)), mul(x, C_CMB));
    @(negedge clk);
    @(negedge clk);
    pm = mul(x, C_MID);
    chk("R1/R8/R9 product", longint'($signed(d_mid)), pm);
    chk("R5 coef max", longint'($signed(d_max)), mul(x, C_MAX));
    chk("R5 coef min", longint'($signed(d_min)), mul(x, C_MIN));
    chk("R6 coef zero", longint'($signed(d_zero)), 0);
    chk("R7 slice", longint'(d_trn), (pm >>> 16) & 64'h1FFFF);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset valid", longint'(v_mid), 0);
    chk("R4 reset data", longint'($signed(d_mid)), 0);
    rst = 1'b0;

    // Table walk with valid_i held low (R9: data path still runs).
    for (int i = 0; i < NVEC; i++) apply(VEC[i]);

    // Random samples.
    for (int i = 0; i < 20; i++) apply(IN_W'($urandom));

    // R2: single valid pulse emerges two edges later.
    @(negedge clk);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R2 valid not early", longint'(v_mid), 0);
    chk("R3 comb valid", longint'(v_cmb), 0);
    @(negedge clk);
    chk("R2 valid aligned", longint'(v_mid), 1);
    chk("R2 valid trunc inst", longint'(v_trn), 1);
    @(negedge clk);
    chk("R2 valid single", longint'(v_mid), 0);

    // R4: reset clears a busy pipeline in one edge.
    din = 27'h4000000;
    valid_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 pre-reset busy", longint'($signed(d_mid)), mul(27'h4000000, C_MID));
    rst = 1'b1;
    @(negedge clk);
    chk("R4 valid cleared", longint'(v_mid), 0);
    chk("R4 data cleared", longint'($signed(d_mid)), 0);
    chk("R4 slice cleared", longint'(d_trn), 0);
    rst = 1'b0;
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 after reset", longint'($signed(d_mid)), mul(27'h4000000, C_MID));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule